// File: doc/BRIEF.md
# UART Host Register Bus Interface

This block is the host-side register front end of a 16550-style UART with enhanced features. A host drives a 3-bit address, an 8-bit data bus, an active-low chip select and separate active-low read and write strobes. These inputs are asynchronous. They pass through a two-stage synchronizer into the system clock domain. An access cycle runs only while the chip select and a strobe are both asserted: the cycle starts on whichever of the two is asserted last, and ends on whichever is released first. The address is taken at cycle start, so the host needs no address strobe.

The block holds the line control, interrupt enable, FIFO control, modem control, enhanced feature and four flow-control character registers. It presents them as outputs to the rest of the UART. Reads return stored registers or status inputs that stand in for the serial datapath. A key value of 0xBF in the line control register swaps the upper addresses to a hidden enhanced bank. The enhanced bits of the interrupt enable, modem control and FIFO control registers can only be changed while the enhanced-enable bit of the enhanced feature register is set.

Top module: `uart_hif`

## Requirements
- R1: A synchronous active-high reset clears every stored register to 0x00, and `dout` reads 0x00 afterwards.
- R2: `dout` is 0x00 unless a read cycle is active. A read cycle begins once both `cs_n` and `rd_n` are low, in either order. It ends as soon as either one goes high. While the cycle is active, `dout` shows the selected register.
- R3: A write cycle is framed by `cs_n` and `wr_n` in the same way. The data present on `din` just before the first release is stored when the cycle ends. The stored registers do not change while the write cycle is still active. Data changes after the release are not stored.
- R4: The address is captured when a cycle starts. Address changes during the cycle have no effect. Address changes while only one of the two signals is asserted also have no effect.
- R5: Standard map, used whenever LCR is not 0xBF: 000 reads `rx_data`; 010 reads `isr_in` and writes FCR; 011 is LCR (read and write); 100 is MCR (read and write); 101 reads `lsr_in`; 110 reads `msr_in`; 111 reads 0x00. Writes to addresses that are read-only are ignored.
- R6: While LCR equals 0xBF, address 010 is the enhanced feature register (EFR). Addresses 100, 101, 110 and 111 are XON1, XON2, XOFF1 and XOFF2, all read and write. Address 011 stays LCR. Addresses 000 and 001 read 0x00.
- R7: IER bits 7:4, MCR bits 7:5 and FCR bits 5:4 are written only while EFR bit 4 is 1. When EFR bit 4 is 0, those bits keep their value and the other bits of the same write are stored.
- R8: With LCR bit 7 clear, address 001 is IER: bit 7 is the auto-CTS interrupt enable, bit 6 the auto-RTS interrupt enable, bit 5 the Xoff interrupt enable and bit 4 the sleep enable. With LCR bit 7 set, addresses 000 and 001 read 0x00, and writes to them leave IER unchanged.
- R9: A write to EFR, XON1, XON2, XOFF1 or XOFF2 happens only while LCR equals 0xBF. Outside the enhanced bank, these registers keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 3 | Register address |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, 0x00 outside a read cycle |
| rx_data | input | 8 | Receive data status stub |
| lsr_in | input | 8 | Line status stub |
| msr_in | input | 8 | Modem status stub |
| isr_in | input | 8 | Interrupt status stub |
| lcr_o | output | 8 | Line control register |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| mcr_o | output | 8 | Modem control register |
| efr_o | output | 8 | Enhanced feature register |
| xon1_o | output | 8 | First XON character |
| xon2_o | output | 8 | Second XON character |
| xoff1_o | output | 8 | First XOFF character |
| xoff2_o | output | 8 | Second XOFF character |

## Verification
The bench drives both assertion orders of select and strobe, and both release orders. A design that starts on the first edge or ends on the last edge shows up in three ways: `dout` drives data while only `cs_n` is low; data stays on `dout` after the strobe is gone; or `din` values that change after the strobe release are stored.

The bench moves the address before and during a cycle, to catch a front end that decodes the live address instead of the captured one. It checks the enhanced-bit gating with the enable bit both clear and set, so that a missing or inverted gate leaves visibly wrong values in IER, MCR and FCR. It checks the LCR 0xBF bank swap in both directions, to catch enhanced registers that leak into the standard map or can be written from it.

// File: rtl/uart_hif_pkg.sv
package uart_hif_pkg;
    localparam int HIF_AW      = 3;
    localparam int HIF_DW      = 8;
    localparam int SYNC_STAGES = 2;
    localparam logic [HIF_DW-1:0] BANK_KEY = 8'hBF;
    localparam int ENH_EN_BIT  = 4;

    typedef struct packed {
        logic [HIF_DW-1:0] lcr;
        logic [HIF_DW-1:0] ier;
        logic [HIF_DW-1:0] fcr;
        logic [HIF_DW-1:0] mcr;
        logic [HIF_DW-1:0] efr;
        logic [HIF_DW-1:0] xon1;
        logic [HIF_DW-1:0] xon2;
        logic [HIF_DW-1:0] xoff1;
        logic [HIF_DW-1:0] xoff2;
    } hif_regs_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic busy;
    } hif_cyc_t;

    function automatic logic in_enh_bank(input logic [HIF_DW-1:0] lcr);
        return lcr == BANK_KEY;
    endfunction

    // merge new data into old value: only bits set in keep_mask are protected
    function automatic logic [HIF_DW-1:0] merge_bits(input logic [HIF_DW-1:0] old_v,
                                                     input logic [HIF_DW-1:0] new_v,
                                                     input logic [HIF_DW-1:0] keep_mask);
        return (old_v & keep_mask) | (new_v & ~keep_mask);
    endfunction
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= RST_VAL;
            else     pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hif_cycle.sv
module hif_cycle
    import uart_hif_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_n,
    input  logic     strb_n,
    output hif_cyc_t cyc
);
    logic act, act_q;

    // both low is the only active state: second assert starts, first release ends
    assign act = ~sel_n & ~strb_n;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= act;
    end

    assign cyc.start = act & ~act_q;
    assign cyc.stop  = ~act & act_q;
    assign cyc.busy  = act_q;
endmodule

// File: rtl/hif_regfile.sv
module hif_regfile
    import uart_hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [HIF_AW-1:0] waddr,
    input  logic [HIF_DW-1:0] wdata,
    input  logic [HIF_AW-1:0] raddr,
    input  logic [HIF_DW-1:0] rx_data,
    input  logic [HIF_DW-1:0] lsr_in,
    input  logic [HIF_DW-1:0] msr_in,
    input  logic [HIF_DW-1:0] isr_in,
    output logic [HIF_DW-1:0] rdata,
    output hif_regs_t         regs
);
    hif_regs_t r;
    logic      bank, enh_on, dl_sel;
    logic [HIF_DW-1:0] ier_keep, mcr_keep, fcr_keep;

    assign bank   = in_enh_bank(r.lcr);
    assign enh_on = r.efr[ENH_EN_BIT];
    assign dl_sel = r.lcr[HIF_DW-1];

    assign ier_keep = enh_on ? 8'h00 : 8'hF0;
    assign mcr_keep = enh_on ? 8'h00 : 8'hE0;
    assign fcr_keep = enh_on ? 8'h00 : 8'h30;

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else if (commit) begin
            case (waddr)
                3'd1: if (!dl_sel) r.ier <= merge_bits(r.ier, wdata, ier_keep);
                3'd2: if (bank) r.efr <= wdata;
                      else      r.fcr <= merge_bits(r.fcr, wdata, fcr_keep);
                3'd3: r.lcr <= wdata;
                3'd4: if (bank) r.xon1 <= wdata;
                      else      r.mcr  <= merge_bits(r.mcr, wdata, mcr_keep);
                3'd5: if (bank) r.xon2  <= wdata;
                3'd6: if (bank) r.xoff1 <= wdata;
                3'd7: if (bank) r.xoff2 <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (bank) begin
            case (raddr)
                3'd2: rdata = r.efr;
                3'd3: rdata = r.lcr;
                3'd4: rdata = r.xon1;
                3'd5: rdata = r.xon2;
                3'd6: rdata = r.xoff1;
                3'd7: rdata = r.xoff2;
                default: rdata = '0;
            endcase
        end else begin
            case (raddr)
                3'd0: rdata = dl_sel ? '0 : rx_data;
                3'd1: rdata = dl_sel ? '0 : r.ier;
                3'd2: rdata = isr_in;
                3'd3: rdata = r.lcr;
                3'd4: rdata = r.mcr;
                3'd5: rdata = lsr_in;
                3'd6: rdata = msr_in;
                default: rdata = '0;
            endcase
        end
    end

    assign regs = r;
endmodule

// File: rtl/uart_hif.sv
module uart_hif
    import uart_hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [HIF_AW-1:0] addr,
    input  logic [HIF_DW-1:0] din,
    output logic [HIF_DW-1:0] dout,
    input  logic [HIF_DW-1:0] rx_data,
    input  logic [HIF_DW-1:0] lsr_in,
    input  logic [HIF_DW-1:0] msr_in,
    input  logic [HIF_DW-1:0] isr_in,
    output logic [HIF_DW-1:0] lcr_o,
    output logic [HIF_DW-1:0] ier_o,
    output logic [HIF_DW-1:0] fcr_o,
    output logic [HIF_DW-1:0] mcr_o,
    output logic [HIF_DW-1:0] efr_o,
    output logic [HIF_DW-1:0] xon1_o,
    output logic [HIF_DW-1:0] xon2_o,
    output logic [HIF_DW-1:0] xoff1_o,
    output logic [HIF_DW-1:0] xoff2_o
);
    localparam int BUS_W = HIF_AW + HIF_DW;

    logic [2:0]        ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic [HIF_AW-1:0] addr_s, addr_q;
    logic [HIF_DW-1:0] din_s, wdata_q, rdata;
    hif_cyc_t          rd_cyc, wr_cyc;
    hif_regs_t         regs;
    logic              wr_end;

    // strobes idle high; data/address delayed equally so they stay aligned
    hif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
        .clk(clk), .rst(rst), .d({cs_n, rd_n, wr_n}), .q(ctl_s));

    hif_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst(rst), .d({addr, din}), .q(bus_s));

    assign {addr_s, din_s} = bus_s;

    hif_cycle u_rd_cyc (.clk(clk), .rst(rst), .sel_n(ctl_s[2]), .strb_n(ctl_s[1]), .cyc(rd_cyc));
    hif_cycle u_wr_cyc (.clk(clk), .rst(rst), .sel_n(ctl_s[2]), .strb_n(ctl_s[0]), .cyc(wr_cyc));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (rd_cyc.start || wr_cyc.start) addr_q <= addr_s;
            if (!ctl_s[2] && !ctl_s[0])       wdata_q <= din_s;
        end
    end

    assign wr_end = wr_cyc.stop;

    hif_regfile u_regs (
        .clk(clk), .rst(rst), .commit(wr_end), .waddr(addr_q), .wdata(wdata_q),
        .raddr(addr_q), .rx_data(rx_data), .lsr_in(lsr_in), .msr_in(msr_in),
        .isr_in(isr_in), .rdata(rdata), .regs(regs));

    assign dout    = rd_cyc.busy ? rdata : '0;
    assign lcr_o   = regs.lcr;
    assign ier_o   = regs.ier;
    assign fcr_o   = regs.fcr;
    assign mcr_o   = regs.mcr;
    assign efr_o   = regs.efr;
    assign xon1_o  = regs.xon1;
    assign xon2_o  = regs.xon2;
    assign xoff1_o = regs.xoff1;
    assign xoff2_o = regs.xoff2;
endmodule

// File: rtl/uart_hif_chk.sv
module uart_hif_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic [7:0] dout,
    input logic       wr_commit,
    input logic [7:0] lcr_o,
    input logic [7:0] ier_o,
    input logic [7:0] fcr_o,
    input logic [7:0] mcr_o,
    input logic [7:0] efr_o,
    input logic [7:0] xon1_o,
    input logic [7:0] xon2_o,
    input logic [7:0] xoff1_o,
    input logic [7:0] xoff2_o
);
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n, 3) || $past(rd_n, 3)) |-> dout == 8'h00); // R2

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_commit) |-> ($stable(lcr_o) && $stable(ier_o) && $stable(mcr_o) && $stable(fcr_o))); // R3

    AST_ENH_BITS_GATED: assert property (@(posedge clk) disable iff (rst)
        !$past(efr_o[4]) |-> ($stable(ier_o[7:4]) && $stable(mcr_o[7:5]) && $stable(fcr_o[5:4]))); // R7

    AST_BANK_LOCKED: assert property (@(posedge clk) disable iff (rst)
        ($past(lcr_o) != 8'hBF) |-> ($stable(efr_o) && $stable(xon1_o) && $stable(xon2_o)
                                     && $stable(xoff1_o) && $stable(xoff2_o))); // R9

    AST_IER_DL_LOCK: assert property (@(posedge clk) disable iff (rst)
        $past(lcr_o[7]) |-> $stable(ier_o)); // R8
endmodule

bind uart_hif uart_hif_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .dout(dout), .wr_commit(wr_end),
    .lcr_o(lcr_o), .ier_o(ier_o), .fcr_o(fcr_o), .mcr_o(mcr_o), .efr_o(efr_o),
    .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o), .xoff2_o(xoff2_o));

// File: tb/uart_hif_test.sv
module uart_hif_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic [7:0] rx_data = 8'h5A, lsr_in = 8'h60, msr_in = 8'hB0, isr_in = 8'hC2;
    logic [7:0] lcr_o, ier_o, fcr_o, mcr_o, efr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    uart_hif uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .din(din), .dout(dout), .rx_data(rx_data), .lsr_in(lsr_in), .msr_in(msr_in),
        .isr_in(isr_in), .lcr_o(lcr_o), .ier_o(ier_o), .fcr_o(fcr_o), .mcr_o(mcr_o),
        .efr_o(efr_o), .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o),
        .xoff2_o(xoff2_o));

    typedef struct packed {
        logic       wr;
        logic [2:0] a;
        logic [7:0] d;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd3, 8'h03, 4'd5},  // R5 LCR write
        '{1'b0, 3'd3, 8'h03, 4'd5},
        '{1'b1, 3'd1, 8'hFF, 4'd7},  // R7 IER upper gated
        '{1'b0, 3'd1, 8'h0F, 4'd7},
        '{1'b1, 3'd4, 8'hFF, 4'd7},  // R7 MCR upper gated
        '{1'b0, 3'd4, 8'h1F, 4'd7},
        '{1'b0, 3'd0, 8'h5A, 4'd5},  // R5 status reads
        '{1'b0, 3'd2, 8'hC2, 4'd5},
        '{1'b0, 3'd5, 8'h60, 4'd5},
        '{1'b0, 3'd6, 8'hB0, 4'd5},
        '{1'b0, 3'd7, 8'h00, 4'd5},
        '{1'b1, 3'd3, 8'hBF, 4'd6},  // R6 enter bank
        '{1'b1, 3'd2, 8'h10, 4'd6},
        '{1'b1, 3'd4, 8'h11, 4'd6},
        '{1'b1, 3'd5, 8'h22, 4'd6},
        '{1'b1, 3'd6, 8'h33, 4'd6},
        '{1'b1, 3'd7, 8'h44, 4'd6},
        '{1'b0, 3'd2, 8'h10, 4'd6},
        '{1'b0, 3'd4, 8'h11, 4'd6},
        '{1'b0, 3'd5, 8'h22, 4'd6},
        '{1'b0, 3'd6, 8'h33, 4'd6},
        '{1'b0, 3'd7, 8'h44, 4'd6},
        '{1'b1, 3'd3, 8'h00, 4'd8},  // R8 leave bank
        '{1'b1, 3'd1, 8'hF5, 4'd7},  // R7 enabled
        '{1'b0, 3'd1, 8'hF5, 4'd8},
        '{1'b1, 3'd4, 8'hE3, 4'd7},
        '{1'b0, 3'd4, 8'hE3, 4'd7},
        '{1'b1, 3'd3, 8'h80, 4'd8},  // R8 LCR bit 7 set
        '{1'b1, 3'd1, 8'h00, 4'd8},
        '{1'b0, 3'd1, 8'h00, 4'd8},
        '{1'b1, 3'd3, 8'h00, 4'd8}
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // order 0: select first, strobe released first; order 1: strobe first, select released first
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input bit order);
        @(negedge clk);
        addr = a; din = d;
        if (!order) cs_n = 1'b0; else wr_n = 1'b0;
        wait_clk(3); @(negedge clk);
        if (!order) wr_n = 1'b0; else cs_n = 1'b0;
        wait_clk(8); @(negedge clk);
        if (!order) wr_n = 1'b1; else cs_n = 1'b1;
        wait_clk(3); @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic bus_read(input logic [2:0] a, input bit order, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        if (!order) cs_n = 1'b0; else rd_n = 1'b0;
        wait_clk(3); @(negedge clk);
        if (!order) rd_n = 1'b0; else cs_n = 1'b0;
        wait_clk(8); @(negedge clk);
        d = dout;
        cs_n = 1'b1; rd_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin
        wait_clk(200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        wait_clk(5);
        @(negedge clk) rst = 1'b0;
        wait_clk(2);
        @(negedge clk);
        // R1 reset state
        check8("R1 lcr", lcr_o, 8'h00);
        check8("R1 ier", ier_o, 8'h00);
        check8("R1 efr", efr_o, 8'h00);
        check8("R1 dout", dout, 8'h00);

        // R7 FCR gate while disabled
        bus_write(3'd2, 8'hFF, 1'b0);
        @(negedge clk);
        check8("R7 fcr gated", fcr_o, 8'hCF);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].a, VECS[i].d, i[0]);
            else begin
                bus_read(VECS[i].a, i[0], rv);
                check8($sformatf("R%0d vec %0d", VECS[i].req, i), rv, VECS[i].d);
            end
        end

        // R9 bank registers untouched from standard map: writes to 101..111 ignored
        bus_write(3'd5, 8'h99, 1'b0);
        bus_write(3'd7, 8'h99, 1'b1);
        @(negedge clk);
        check8("R9 xon2", xon2_o, 8'h22);
        check8("R9 xoff2", xoff2_o, 8'h44);
        check8("R9 efr", efr_o, 8'h10);
        check8("R8 ier after dl", ier_o, 8'hF5);

        // R7 FCR gate while enabled
        bus_write(3'd2, 8'hFF, 1'b1);
        @(negedge clk);
        check8("R7 fcr enabled", fcr_o, 8'hFF);

        // R2 / R4: address moves while only select is low; start is the strobe
        @(negedge clk);
        addr = 3'd0; cs_n = 1'b0;
        wait_clk(8); @(negedge clk);
        check8("R2 select only idle", dout, 8'h00);
        addr = 3'd4;
        wait_clk(2); @(negedge clk);
        rd_n = 1'b0;
        wait_clk(8); @(negedge clk);
        check8("R4 addr at start", dout, 8'hE3);
        addr = 3'd5;
        wait_clk(8); @(negedge clk);
        check8("R4 addr moved mid cycle", dout, 8'hE3);
        rd_n = 1'b1;
        wait_clk(6); @(negedge clk);
        check8("R2 ends at first release", dout, 8'h00);
        cs_n = 1'b1;
        wait_clk(6);

        // R3: commit on end, late data ignored
        @(negedge clk);
        addr = 3'd3; din = 8'h07; cs_n = 1'b0; wr_n = 1'b0;
        wait_clk(8); @(negedge clk);
        check8("R3 no commit while active", lcr_o, 8'h00);
        wr_n = 1'b1;
        @(negedge clk);
        din = 8'h55; addr = 3'd4;
        wait_clk(8); @(negedge clk);
        check8("R3 lcr commit", lcr_o, 8'h07);
        check8("R3 mcr untouched", mcr_o, 8'hE3);
        cs_n = 1'b1;
        wait_clk(6); @(negedge clk);
        check8("R3 late data not stored", lcr_o, 8'h07);

        // R1 reset mid-run
        rst = 1'b1;
        wait_clk(5); @(negedge clk);
        rst = 1'b0;
        wait_clk(2); @(negedge clk);
        check8("R1 lcr again", lcr_o, 8'h00);
        check8("R1 mcr again", mcr_o, 8'h00);
        check8("R1 xon1 again", xon1_o, 8'h00);
        check8("R1 fcr again", fcr_o, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule